// File: doc/BRIEF.md
# Audio Decoder Control Register Slave (Two-Wire Bus)

This block sits on the two-wire serial control bus of a TV multichannel sound decoder. It keeps the decoder's control settings, such as input gain trim, the separation trims, the source, mono and mute selects, and the per-channel volume. These settings are visible as parallel register fields to the rest of the decoder. A host writes the settings through a write transaction. The transaction opens with a sub-address byte, and the data bytes that follow fill successive registers. A read transaction returns a status byte. It reports the carrier and noise detectors of the decoder, together with a sticky flag that shows a reset has taken place.

SCL and SDA are sampled by the system clock through synchronisers. Start and stop conditions are recovered from the synchronised lines. The slave never drives SDA high; it only pulls it low through `sda_oe`, and the pad combines that pull with the line. Each setting has its own reset value, so the decoder starts in a usable state before the host writes anything.

Top module: `tvaud_ctrl_i2c`

## Requirements
- R1: After reset the fields hold in_gain=0x9, sep_hf=0x1F, sep_lf=0x1F, out_enable=1 and vol_l=vol_r=0x3F. Every other field is 0.
- R2: The address byte 0x84 (write) and the address byte 0x85 (read) are acknowledged. Any other address byte, and every byte after it up to the next start condition, gets no acknowledge and changes no field.
- R3: Only the low 4 bits of the sub-address byte select the starting register. Its upper 4 bits have no effect.
- R4: Each data byte of a write lands in the register the pointer selects, and the pointer then advances by one. Several data bytes therefore fill consecutive registers.
- R5: Field positions by sub-address:
  - 0: bit 7 dac_test, bit 6 bpf_mon, bits 3:0 in_gain
  - 1: bits 5:0 sep_hf
  - 2: bits 5:0 sep_lf
  - 3: bit 4 aux_sel, bit 3 nr_src_sap, bit 2 force_mono, bit 1 out_enable, bit 0 sap_always
  - 4: bits 5:0 vol_l
  - 5: bits 5:0 vol_r
- R6: Data bytes aimed at sub-addresses 6 to 15 are acknowledged and leave every field unchanged. The pointer wraps from 15 to 0.
- R7: A read byte is {sap_det, noise_det, 4'b0000, reset flag, stereo_det}, sent MSB first. A 1 in a bit means the condition is present.
- R8: The reset flag reads 1 in the first status byte sent after reset and 0 in every later status byte until the next reset. When the host acknowledges a read byte, a fresh status byte follows.
- R9: The slave pulls SDA low only in the acknowledge slot of an accepted byte and in the 0 bits of a read byte. It leaves SDA released while it receives bits and after a stop condition.
- R10: A start condition in the middle of a transfer, even part way through a byte, discards the partial byte and makes the next byte an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sap_det | input | 1 | Second-program carrier detected |
| noise_det | input | 1 | Second-program noise detected |
| stereo_det | input | 1 | Stereo pilot detected |
| dac_test | output | 1 | Trim-DAC test select |
| bpf_mon | output | 1 | Band-pass monitor test select |
| in_gain | output | 4 | Input level trim |
| sep_hf | output | 6 | High-frequency separation trim |
| sep_lf | output | 6 | Low-frequency separation trim |
| aux_sel | output | 1 | External input select |
| nr_src_sap | output | 1 | Noise-reduction source: 0 difference channel, 1 second program |
| force_mono | output | 1 | Forced mono |
| out_enable | output | 1 | 0 mutes the line outputs |
| sap_always | output | 1 | Select second program even without carrier detection |
| vol_l | output | 6 | Left volume |
| vol_r | output | 6 | Right volume |

## Verification
Two functions of the receiver can fall on the same cycle: a start condition, and the shifting of a bit into a byte. The bench provokes this with a repeated start after four data bits. The start task raises SCL, and that rising edge both shifts a bit and comes just before the SDA fall that restarts the receiver. The test is judged by two things. The register the abandoned byte pointed at must keep its old value on every compared clock. The byte that follows the restart must be accepted as an address, and its write must reach the right fields. A second overlap is the status snapshot, which coincides with clearing the reset flag. Back-to-back acknowledged reads check that the first byte carries the flag and the next does not.

// File: rtl/tvaud_i2c_pkg.sv
package tvaud_i2c_pkg;
  localparam logic [6:0] DEV_ADDR = 7'h42;   // 0x84 write / 0x85 read
  localparam int         NREG     = 6;
  localparam int         SUB_W    = 4;
  localparam int         BYTE_W   = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_TXACK, S_TXLOAD
  } bus_st_t;

  typedef enum logic [1:0] {PH_ADDR, PH_SUB, PH_DATA} phase_t;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h09;
      1, 2:    return 8'h1F;
      3:       return 8'h02;
      4, 5:    return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev, scl_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin scl_pipe <= '1; sda_pipe <= '1; end
        else begin scl_pipe <= scl_i; sda_pipe <= sda_i; end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin scl_pipe <= '1; sda_pipe <= '1; end
        else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_q = scl_pipe[STAGES-1];
  assign sda_q = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin scl_prev <= 1'b1; sda_prev <= 1'b1; end
    else begin scl_prev <= scl_q; sda_prev <= sda_q; end
  end

  assign scl_rise = scl_q & ~scl_prev;
  assign scl_fall = ~scl_q & scl_prev;
  assign start_c  = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_c   = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import tvaud_i2c_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_c,
  input  logic             stop_c,
  input  logic [7:0]       status,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [SUB_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             load_status
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  bus_st_t          state;
  phase_t           phase;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       shreg;
  logic [SUB_W-1:0] ptr;
  logic             rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; phase <= PH_ADDR; bitcnt <= '0; shreg <= '0;
      ptr <= '0; rd <= 1'b0; sda_oe <= 1'b0; wr_en <= 1'b0;
      wr_addr <= '0; wr_data <= '0; load_status <= 1'b0;
    end else begin
      wr_en       <= 1'b0;
      load_status <= 1'b0;
      if (start_c) begin
        state <= S_RX; phase <= PH_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_q};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              case (phase)
                PH_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rd <= shreg[0]; sda_oe <= 1'b1; state <= S_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                PH_SUB: begin
                  ptr <= shreg[SUB_W-1:0]; sda_oe <= 1'b1; state <= S_ACK;
                end
                default: begin
                  wr_en <= 1'b1; wr_addr <= ptr; wr_data <= shreg;
                  ptr <= ptr + 1'b1; sda_oe <= 1'b1; state <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (phase == PH_ADDR && rd) begin
                shreg <= status; sda_oe <= ~status[7];
                load_status <= 1'b1; state <= S_TX;
              end else begin
                sda_oe <= 1'b0; state <= S_RX;
                phase  <= (phase == PH_ADDR) ? PH_SUB : PH_DATA;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0; bitcnt <= '0; state <= S_TXACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) state <= sda_q ? S_IDLE : S_TXLOAD;
          end
          S_TXLOAD: begin
            if (scl_fall) begin
              shreg <= status; sda_oe <= ~status[7];
              load_status <= 1'b1; state <= S_TX;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R2: a non-matching address byte is never acknowledged
  p_nack_foreign_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_RX && phase == PH_ADDR && scl_fall && !start_c && !stop_c &&
     bitcnt == LAST_BIT && shreg[7:1] != DEV_ADDR) |=> !sda_oe);

  // R4: the pointer has moved past the register being written
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ptr == wr_addr + 1'b1);

  // R9: SDA released after stop and while bits are being received
  p_release_stop_r9: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !sda_oe);
  p_quiet_rx_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_RX) |-> !sda_oe);
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
  import tvaud_i2c_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SUB_W-1:0]           wr_addr,
  input  logic [7:0]                 wr_data,
  output logic [NREG-1:0][7:0]       regs_q
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        regs_q[i] <= reg_default(i);
      else if (wr_en && wr_addr == SUB_W'(i))
        regs_q[i] <= wr_data;
    end
  end

  // R6: writes outside the implemented range change nothing
  p_discard_high_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) >= NREG) |=> $stable(regs_q));

  // R4: registers only move when a data byte is committed
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/tvaud_ctrl_i2c.sv
module tvaud_ctrl_i2c
  import tvaud_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       sap_det,
  input  logic       noise_det,
  input  logic       stereo_det,
  output logic       dac_test,
  output logic       bpf_mon,
  output logic [3:0] in_gain,
  output logic [5:0] sep_hf,
  output logic [5:0] sep_lf,
  output logic       aux_sel,
  output logic       nr_src_sap,
  output logic       force_mono,
  output logic       out_enable,
  output logic       sap_always,
  output logic [5:0] vol_l,
  output logic [5:0] vol_r
);
  logic sda_q, scl_rise, scl_fall, start_c, stop_c;
  logic wr_en, load_status, por_flag;
  logic [SUB_W-1:0]     wr_addr;
  logic [7:0]           wr_data, status;
  logic [NREG-1:0][7:0] regs_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  i2c_byte_engine u_eng (
    .clk(clk), .rst(rst), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .status(status), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .load_status(load_status)
  );

  ctrl_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_q(regs_q)
  );

  always_ff @(posedge clk) begin
    if (rst)              por_flag <= 1'b1;
    else if (load_status) por_flag <= 1'b0;
  end

  assign status = {sap_det, noise_det, 4'b0000, por_flag, stereo_det};

  assign dac_test   = regs_q[0][7];
  assign bpf_mon    = regs_q[0][6];
  assign in_gain    = regs_q[0][3:0];
  assign sep_hf     = regs_q[1][5:0];
  assign sep_lf     = regs_q[2][5:0];
  assign aux_sel    = regs_q[3][4];
  assign nr_src_sap = regs_q[3][3];
  assign force_mono = regs_q[3][2];
  assign out_enable = regs_q[3][1];
  assign sap_always = regs_q[3][0];
  assign vol_l      = regs_q[4][5:0];
  assign vol_r      = regs_q[5][5:0];

  logic unused_reg_bits;
  assign unused_reg_bits = ^{regs_q[0][5:4], regs_q[1][7:6], regs_q[2][7:6],
                             regs_q[3][7:5], regs_q[4][7:6], regs_q[5][7:6]};

  // R8: the reset flag only drops when a status byte was taken
  p_por_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(por_flag) |-> $past(load_status));
endmodule

// File: tb/sim_tvaud_ctrl_i2c.sv
module sim_tvaud_ctrl_i2c;
  localparam int CLK_NS   = 10;
  localparam int Q        = 10;       // clocks per quarter bit
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic sclm = 1'b1, sdam = 1'b1;
  logic sap_det = 0, noise_det = 0, stereo_det = 0;
  logic sda_oe, dac_test, bpf_mon, aux_sel, nr_src_sap, force_mono, out_enable, sap_always;
  logic [3:0] in_gain;
  logic [5:0] sep_hf, sep_lf, vol_l, vol_r;
  wire sda_line = sdam & ~sda_oe;

  int cyc = 0, last_edge = 0, n_chk = 0, n_bad = 0;
  bit chk_on = 0, done = 0;
  logic [7:0] exp_reg [6];
  bit exp_por;

  tvaud_ctrl_i2c u0 (
    .clk(clk), .rst(rst), .scl_i(sclm), .sda_i(sda_line), .sda_oe(sda_oe),
    .sap_det(sap_det), .noise_det(noise_det), .stereo_det(stereo_det),
    .dac_test(dac_test), .bpf_mon(bpf_mon), .in_gain(in_gain), .sep_hf(sep_hf),
    .sep_lf(sep_lf), .aux_sel(aux_sel), .nr_src_sap(nr_src_sap),
    .force_mono(force_mono), .out_enable(out_enable), .sap_always(sap_always),
    .vol_l(vol_l), .vol_r(vol_r)
  );

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [34:0] act_vec();
    return {dac_test, bpf_mon, in_gain, sep_hf, sep_lf, aux_sel, nr_src_sap,
            force_mono, out_enable, sap_always, vol_l, vol_r};
  endfunction
  function automatic logic [34:0] exp_vec();
    return {exp_reg[0][7], exp_reg[0][6], exp_reg[0][3:0], exp_reg[1][5:0],
            exp_reg[2][5:0], exp_reg[3][4:0], exp_reg[4][5:0], exp_reg[5][5:0]};
  endfunction

  // per-clock comparison of the field outputs against the model (R5)
  always @(negedge clk) begin
    if (chk_on && !rst && (cyc - last_edge) > 8)
      chk(act_vec() == exp_vec(), "R5", "field vector", act_vec(), exp_vec());
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic set_scl(input logic v); sclm = v; last_edge = cyc; endtask
  task automatic set_sda(input logic v); sdam = v; last_edge = cyc; endtask

  task automatic bus_start();
    wq(); set_sda(1); wq(); set_scl(1); wq(); set_sda(0); wq(); set_scl(0);
  endtask
  task automatic bus_stop();
    wq(); set_sda(0); wq(); set_scl(1); wq(); set_sda(1); wq();
  endtask
  task automatic send_bit(input logic b);
    wq(); set_sda(b); wq(); set_scl(1); wq(); wq(); set_scl(0);
  endtask
  task automatic recv_bit(output logic b);
    wq(); set_sda(1); wq(); set_scl(1); wq(); b = sda_line; wq(); set_scl(0);
  endtask
  task automatic send8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic do_reset();
    sclm = 1; sdam = 1; rst = 1;
    exp_reg = '{8'h09, 8'h1F, 8'h1F, 8'h02, 8'h3F, 8'h3F};
    exp_por = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    last_edge = cyc;
  endtask

  // write transaction; model decides acks and register effects (R2,R3,R4,R6)
  task automatic write_txn(input logic [7:0] addr, input logic [7:0] sub,
                           input logic [7:0] d[$]);
    logic a;
    bit   ok = (addr == 8'h84);
    int   ptr;
    bus_start();
    send8(addr); recv_bit(a);
    chk(a == !ok, "R2", "address ack (0=ack)", a, !ok);
    send8(sub); recv_bit(a);
    chk(a == !ok, "R2", "sub-address ack (0=ack)", a, !ok);
    ptr = sub & 15;
    foreach (d[k]) begin
      send8(d[k]);
      if (ok) begin
        if (ptr < 6) exp_reg[ptr] = d[k];
        ptr = (ptr + 1) % 16;
      end
      recv_bit(a);
      chk(a == !ok, "R6", "data ack (0=ack)", a, !ok);
    end
    bus_stop();
    chk(sda_line == 1'b1, "R9", "line released after stop", sda_line, 1);
  endtask

  // read transaction of n status bytes (R7, R8)
  task automatic read_txn(input int n);
    logic a;
    logic [7:0] got, want;
    bus_start();
    send8(8'h85); recv_bit(a);
    chk(a == 1'b0, "R2", "read address ack (0=ack)", a, 0);
    for (int k = 0; k < n; k++) begin
      want = {sap_det, noise_det, 4'b0000, exp_por, stereo_det};
      for (int i = 7; i >= 0; i--) recv_bit(got[i]);
      chk(got == want, "R7", "status byte", got, want);
      chk(got[1] == exp_por, "R8", "reset flag", got[1], exp_por);
      exp_por = 0;
      send_bit(k == n - 1);
    end
    bus_stop();
    chk(sda_line == 1'b1, "R9", "line released after read", sda_line, 1);
  endtask

  initial begin
    wait (cyc >= WD_LIMIT);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual cycles=%0d expected<%0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    do_reset();
    repeat (20) @(negedge clk);
    // R1: defaults at the ports
    chk(act_vec() == exp_vec(), "R1", "reset fields", act_vec(), exp_vec());
    chk(sda_oe == 1'b0, "R9", "sda released in reset state", sda_oe, 0);
    chk_on = 1;

    // R4/R5: burst fill of all six registers
    write_txn(8'h84, 8'h00, '{8'hC5, 8'h2A, 8'h15, 8'h1D, 8'h10, 8'h20});
    // R3: upper sub-address bits ignored
    write_txn(8'h84, 8'hF3, '{8'h02});
    // R6: discard at 6, then 14/15 discarded and wrap to 0
    write_txn(8'h84, 8'h05, '{8'h11, 8'h22});
    write_txn(8'h84, 8'h0E, '{8'hAA, 8'hBB, 8'h07});
    // R2: foreign addresses, including the read address's neighbour
    write_txn(8'h86, 8'h00, '{8'h00});
    write_txn(8'h40, 8'h04, '{8'h00});

    // R7/R8: reads with different detector patterns
    sap_det = 1; noise_det = 0; stereo_det = 1;
    read_txn(1);
    read_txn(1);
    sap_det = 0; noise_det = 1; stereo_det = 0;
    read_txn(2);

    // R10: repeated start after a complete write byte
    bus_start();
    send8(8'h84); recv_bit(a); send8(8'h04); recv_bit(a);
    send8(8'h05); exp_reg[4] = 8'h05; recv_bit(a);
    chk(a == 1'b0, "R10", "data ack before restart", a, 0);
    bus_start();
    send8(8'h84); recv_bit(a);
    chk(a == 1'b0, "R10", "address ack after restart", a, 0);
    send8(8'h05); recv_bit(a);
    send8(8'h3A); exp_reg[5] = 8'h3A; recv_bit(a);
    bus_stop();

    // R10: restart part way through a byte; partial byte discarded
    bus_start();
    send8(8'h84); recv_bit(a); send8(8'h01); recv_bit(a);
    send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    bus_start();
    send8(8'h84); recv_bit(a);
    chk(a == 1'b0, "R10", "address ack after mid-byte restart", a, 0);
    send8(8'h01); recv_bit(a);
    send8(8'h0C); exp_reg[1] = 8'h0C; recv_bit(a);
    bus_stop();
    chk(sep_hf == 6'h0C, "R10", "sep_hf after restart", sep_hf, 6'h0C);

    // R1/R8: a second reset restores defaults and the flag
    chk_on = 0;
    do_reset();
    repeat (20) @(negedge clk);
    chk(act_vec() == exp_vec(), "R1", "fields after second reset", act_vec(), exp_vec());
    chk_on = 1;
    sap_det = 1; noise_det = 1; stereo_det = 0;
    read_txn(2);

    repeat (20) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule